// File: doc/BRIEF.md
# UART Register Bank with Interrupt Logic

This block is the software-facing half of a UART. It decodes a 4 KB, 32-bit, word-addressed window on an APB-style bus. It holds the configuration state that the serial engines consume: the enables, the line format, the two-part baud divisor, the FIFO level selects, the DMA selects and the low-power divisor. It builds the status flag word from the FIFO status inputs. It keeps the raw receive and transmit interrupt bits, masks them, and drives one interrupt line.

Software sends a byte by writing the data word. The byte goes out on a one-cycle push strobe only when the UART is enabled, transmit is enabled and loopback is off. Any write that passes the enable gate sets the transmit interrupt, and this includes a write made while loopback is on. A read of the data word pops the receive FIFO and returns its head byte, or returns 0 when the FIFO is empty. Eight identification bytes sit in the top eight words of the window.

Bus phases are tracked by a two-state machine. In PH_IDLE, a selected cycle without enable takes the transition SETUP_SEEN into PH_SETUP. In PH_SETUP, a cycle with both select and enable is the access cycle: pready is high, the transfer completes, and the transition DONE returns the machine to PH_IDLE. A setup that is repeated keeps the machine in PH_SETUP (transition HOLD). Dropping select takes the transition ABANDON back to PH_IDLE.

Top module: `uart_regbank`

## Requirements
- R1: After reset the control word reads 0x300 (bits 8 and 9 set). Mask, raw status, baud, line, level, DMA and low-power registers read 0, and irq_o is low.
- R2: pready is high only in an access cycle (psel and penable) that directly follows a setup cycle. It is never high in two consecutive cycles, and every register read or write takes effect only in that cycle.
- R3: The writable registers read back the written value truncated to their field widths. The widths are: low-power divisor 0x020 8 bits, integer baud 0x024 16 bits, fractional baud 0x028 6 bits, line control 0x02C 8 bits, control 0x030 16 bits, FIFO level 0x034 6 bits, mask 0x038 11 bits, DMA control 0x048 3 bits.
- R4: The flag word at 0x018 shows rx_empty_i at bit 4, tx_full_i at bit 5, rx_full_i at bit 6 and tx_empty_i at bit 7. All other bits read 0.
- R5: A write to data offset 0x000 pulses tx_push_o with tx_data_o = pwdata[7:0] only if control bit 0 (enable) and bit 8 (transmit enable) are set and bit 7 (loopback) is clear.
- R6: A data write with bits 0 and 8 set sets raw status bit 5, whether or not loopback is on. If either bit is clear, the write has no effect.
- R7: A pulse on rx_push_i sets raw status bit 4. The bit clears once rx_empty_i is high.
- R8: A write to 0x044 clears each raw status bit written as 1 and leaves the others unchanged. Raw status at 0x03C has only bits 4 and 5 ever set.
- R9: Masked status at 0x040 equals raw AND mask. irq_o is high exactly when masked status is nonzero, and it follows a mask write from the next cycle.
- R10: Reads of 0x004 and 0x044 return 0. Writes to 0x004 and 0x018 change nothing.
- R11: The words at 0xFE0 through 0xFFC read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one byte per word in ascending address order.
- R12: A read of 0x000 pops the receive FIFO (rx_pop_o for one cycle) and returns rx_data_i when rx_empty_i is low. When rx_empty_i is high, the read returns 0 and does not pop.
- R13: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid when pready is high |
| pready | output | 1 | Transfer completes this cycle |
| tx_push_o | output | 1 | Push strobe to the transmit FIFO |
| tx_data_o | output | 8 | Byte to push |
| rx_pop_o | output | 1 | Pop strobe to the receive FIFO |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| rx_push_i | input | 1 | A byte has entered the receive FIFO |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_full_i | input | 1 | Transmit FIFO full |
| irq_o | output | 1 | Combined interrupt |
| ctrl_o | output | 16 | Control word |
| line_ctrl_o | output | 8 | Line format word |
| baud_int_o | output | 16 | Integer baud divisor |
| baud_frac_o | output | 6 | Fractional baud divisor |
| fifo_lvl_o | output | 6 | FIFO level selects |
| dma_ctrl_o | output | 3 | DMA selects |
| lp_div_o | output | 8 | Low-power divisor |

## Verification
The bench builds the block with its default 12-bit address and the default field widths. This puts the whole 4 KB window within reach, so every mapped word, the full identification block and long runs of unmapped words are all read. Within that window the bench sweeps every combination of the enable, loopback and transmit-enable bits. It also sweeps every clear pattern over the two raw bits and every pairing of raw and mask over those bits. Expected values come from the bit positions and field widths.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
    localparam int DATA_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int LPDIV_W     = 8;
    localparam int BAUD_INT_W  = 16;
    localparam int BAUD_FRAC_W = 6;
    localparam int LINE_W      = 8;
    localparam int CTRL_W      = 16;
    localparam int LVL_W       = 6;
    localparam int MASK_W      = 11;
    localparam int DMA_W       = 3;
    localparam int ID_WORDS    = 8;

    // word indices (byte offset / 4)
    localparam int W_DATA  = 0;
    localparam int W_RSTAT = 1;
    localparam int W_FLAG  = 6;
    localparam int W_LPDIV = 8;
    localparam int W_BINT  = 9;
    localparam int W_BFRAC = 10;
    localparam int W_LINE  = 11;
    localparam int W_CTRL  = 12;
    localparam int W_LVL   = 13;
    localparam int W_MASK  = 14;
    localparam int W_RAW   = 15;
    localparam int W_MIS   = 16;
    localparam int W_CLR   = 17;
    localparam int W_DMA   = 18;

    // bit positions that neighbours decode
    localparam int C_EN   = 0;
    localparam int C_LOOP = 7;
    localparam int C_TXEN = 8;
    localparam int C_RXEN = 9;
    localparam int I_RX   = 4;
    localparam int I_TX   = 5;

    typedef enum logic [0:0] {PH_IDLE = 1'b0, PH_SETUP = 1'b1} bus_ph_e;
endpackage

// File: rtl/uart_bus_fsm.sv
module uart_bus_fsm
    import uart_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic acc_o
);
    bus_ph_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE:  if (psel && !penable) st_d = PH_SETUP;  // SETUP_SEEN
            PH_SETUP: begin
                if (!psel)        st_d = PH_IDLE;              // ABANDON
                else if (penable) st_d = PH_IDLE;              // DONE
                else              st_d = PH_SETUP;             // HOLD
            end
            default:  st_d = PH_IDLE;
        endcase
    end

    always_comb acc_o = (st_q == PH_SETUP) && psel && penable;

    // R2
    acc_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> (psel && penable));
    // R2
    acc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |=> !acc_o);
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_set_i,
    input  logic              rx_set_i,
    input  logic              rx_empty_i,
    input  logic              clr_we_i,
    input  logic              mask_we_i,
    input  logic [MASK_W-1:0] wdata_i,
    output logic [MASK_W-1:0] raw_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              irq_o
);
    logic rx_q, tx_q;
    logic [MASK_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= 1'b0;
            tx_q   <= 1'b0;
            mask_q <= '0;
        end else begin
            if (rx_set_i)                              rx_q <= 1'b1;
            else if ((clr_we_i && wdata_i[I_RX]) || rx_empty_i) rx_q <= 1'b0;
            if (tx_set_i)                              tx_q <= 1'b1;
            else if (clr_we_i && wdata_i[I_TX])        tx_q <= 1'b0;
            if (mask_we_i)                             mask_q <= wdata_i;
        end
    end

    always_comb begin
        raw_o       = '0;
        raw_o[I_RX] = rx_q;
        raw_o[I_TX] = tx_q;
        mask_o      = mask_q;
        irq_o       = |(raw_o & mask_q);
    end

    // R6
    tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set_i |=> raw_o[I_TX]);
    // R7
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set_i |=> raw_o[I_RX]);
    // R8
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && wdata_i[I_TX] && !tx_set_i) |=> !raw_o[I_TX]);
    // R9
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_o != '0));
endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom
    import uart_regbank_pkg::*;
(
    input  logic [2:0]        sel_i,
    output logic [BYTE_W-1:0] byte_o
);
    always_comb begin
        unique case (sel_i)
            3'd0: byte_o = 8'h11;
            3'd1: byte_o = 8'h10;
            3'd2: byte_o = 8'h14;
            3'd3: byte_o = 8'h00;
            3'd4: byte_o = 8'h0D;
            3'd5: byte_o = 8'hF0;
            3'd6: byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [DATA_W-1:0]      pwdata,
    output logic [DATA_W-1:0]      prdata,
    output logic                   pready,
    output logic                   tx_push_o,
    output logic [BYTE_W-1:0]      tx_data_o,
    output logic                   rx_pop_o,
    input  logic [BYTE_W-1:0]      rx_data_i,
    input  logic                   rx_push_i,
    input  logic                   rx_empty_i,
    input  logic                   rx_full_i,
    input  logic                   tx_empty_i,
    input  logic                   tx_full_i,
    output logic                   irq_o,
    output logic [CTRL_W-1:0]      ctrl_o,
    output logic [LINE_W-1:0]      line_ctrl_o,
    output logic [BAUD_INT_W-1:0]  baud_int_o,
    output logic [BAUD_FRAC_W-1:0] baud_frac_o,
    output logic [LVL_W-1:0]       fifo_lvl_o,
    output logic [DMA_W-1:0]       dma_ctrl_o,
    output logic [LPDIV_W-1:0]     lp_div_o
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int ID_BASE = (1 << IDX_W) - ID_WORDS;

    logic             acc, wr, rd;
    logic [IDX_W-1:0] idx;
    logic [MASK_W-1:0] raw, mask;
    logic [BYTE_W-1:0] id_byte;
    logic             tx_ok;

    uart_bus_fsm u_fsm (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .acc_o(acc));

    always_comb begin
        idx    = paddr[ADDR_W-1:2];
        wr     = acc && pwrite;
        rd     = acc && !pwrite;
        pready = acc;
        tx_ok  = ctrl_o[C_EN] && ctrl_o[C_TXEN];
        tx_push_o = wr && (idx == IDX_W'(W_DATA)) && tx_ok && !ctrl_o[C_LOOP];
        tx_data_o = pwdata[BYTE_W-1:0];
        rx_pop_o  = rd && (idx == IDX_W'(W_DATA)) && !rx_empty_i;
    end

    uart_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_set_i(wr && (idx == IDX_W'(W_DATA)) && tx_ok),
        .rx_set_i(rx_push_i), .rx_empty_i(rx_empty_i),
        .clr_we_i(wr && (idx == IDX_W'(W_CLR))),
        .mask_we_i(wr && (idx == IDX_W'(W_MASK))),
        .wdata_i(pwdata[MASK_W-1:0]),
        .raw_o(raw), .mask_o(mask), .irq_o(irq_o)
    );

    uart_id_rom u_id (.sel_i(idx[2:0]), .byte_o(id_byte));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o      <= CTRL_W'((1 << C_TXEN) | (1 << C_RXEN));
            line_ctrl_o <= '0;
            baud_int_o  <= '0;
            baud_frac_o <= '0;
            fifo_lvl_o  <= '0;
            dma_ctrl_o  <= '0;
            lp_div_o    <= '0;
        end else if (wr) begin
            if (idx == IDX_W'(W_CTRL))  ctrl_o      <= pwdata[CTRL_W-1:0];
            if (idx == IDX_W'(W_LINE))  line_ctrl_o <= pwdata[LINE_W-1:0];
            if (idx == IDX_W'(W_BINT))  baud_int_o  <= pwdata[BAUD_INT_W-1:0];
            if (idx == IDX_W'(W_BFRAC)) baud_frac_o <= pwdata[BAUD_FRAC_W-1:0];
            if (idx == IDX_W'(W_LVL))   fifo_lvl_o  <= pwdata[LVL_W-1:0];
            if (idx == IDX_W'(W_DMA))   dma_ctrl_o  <= pwdata[DMA_W-1:0];
            if (idx == IDX_W'(W_LPDIV)) lp_div_o    <= pwdata[LPDIV_W-1:0];
        end
    end

    always_comb begin
        prdata = '0;
        if (rd) begin
            if (idx >= IDX_W'(ID_BASE)) prdata = DATA_W'(id_byte);
            else if (idx == IDX_W'(W_DATA))  prdata = rx_empty_i ? '0 : DATA_W'(rx_data_i);
            else if (idx == IDX_W'(W_FLAG))  prdata = DATA_W'({tx_empty_i, rx_full_i, tx_full_i, rx_empty_i, 4'b0});
            else if (idx == IDX_W'(W_LPDIV)) prdata = DATA_W'(lp_div_o);
            else if (idx == IDX_W'(W_BINT))  prdata = DATA_W'(baud_int_o);
            else if (idx == IDX_W'(W_BFRAC)) prdata = DATA_W'(baud_frac_o);
            else if (idx == IDX_W'(W_LINE))  prdata = DATA_W'(line_ctrl_o);
            else if (idx == IDX_W'(W_CTRL))  prdata = DATA_W'(ctrl_o);
            else if (idx == IDX_W'(W_LVL))   prdata = DATA_W'(fifo_lvl_o);
            else if (idx == IDX_W'(W_MASK))  prdata = DATA_W'(mask);
            else if (idx == IDX_W'(W_RAW))   prdata = DATA_W'(raw);
            else if (idx == IDX_W'(W_MIS))   prdata = DATA_W'(raw & mask);
            else if (idx == IDX_W'(W_DMA))   prdata = DATA_W'(dma_ctrl_o);
        end
    end

    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_o |-> (ctrl_o[C_EN] && ctrl_o[C_TXEN] && !ctrl_o[C_LOOP]));
    // R12
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> !rx_empty_i);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push_o, rx_pop_o}));
    // R2
    strobe_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_o || rx_pop_o) |-> pready);
endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, tx_push_o, rx_pop_o, irq_o;
    logic [7:0] tx_data_o, rx_data_i = 8'h00;
    logic rx_push_i = 0, rx_empty_i = 1, rx_full_i = 0, tx_empty_i = 1, tx_full_i = 0;
    logic [15:0] ctrl_o, baud_int_o;
    logic [7:0]  line_ctrl_o, lp_div_o;
    logic [5:0]  baud_frac_o, fifo_lvl_o;
    logic [2:0]  dma_ctrl_o;

    int checks = 0, errors = 0;
    logic seen_push, seen_pop, seen_ready;
    logic [7:0] seen_txd;

    always #2 clk = ~clk;

    uart_regbank dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1;
        r = prdata; seen_push = tx_push_o; seen_pop = rx_pop_o;
        seen_txd = tx_data_o; seen_ready = pready;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r;
        xfer(1'b1, a, d, r);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r);
        xfer(1'b0, a, 32'h0, r);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd(12'h030, r); chk("R1 ctrl", r, 32'h300);
        rd(12'h038, r); chk("R1 mask", r, 0);
        rd(12'h03C, r); chk("R1 raw", r, 0);
        rd(12'h024, r); chk("R1 baud", r, 0);
        chk("R1 irq", irq_o, 0);
        chk("R2 pready in access", seen_ready, 1);
        #1; chk("R2 pready idle", pready, 0);

        // R4 flag positions, all 16 input combos
        for (int k = 0; k < 16; k++) begin
            {tx_empty_i, rx_full_i, tx_full_i, rx_empty_i} = 4'(k);
            rd(12'h018, r); chk("R4 flags", r, 32'(k) << 4);
        end
        {tx_empty_i, rx_full_i, tx_full_i, rx_empty_i} = 4'b1001;
        wr(12'h018, 32'hFFFF_FFFF); rd(12'h018, r); chk("R10 flag write ignored", r, 32'h90);

        // R3 readback with field widths
        for (int p = 0; p < 2; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_FFFF : 32'hA5A5_5A5A;
            wr(12'h020, pat); rd(12'h020, r); chk("R3 lpdiv", r, pat & 32'hFF);
            wr(12'h024, pat); rd(12'h024, r); chk("R3 bint", r, pat & 32'hFFFF);
            wr(12'h028, pat); rd(12'h028, r); chk("R3 bfrac", r, pat & 32'h3F);
            wr(12'h02C, pat); rd(12'h02C, r); chk("R3 line", r, pat & 32'hFF);
            wr(12'h034, pat); rd(12'h034, r); chk("R3 lvl", r, pat & 32'h3F);
            wr(12'h048, pat); rd(12'h048, r); chk("R3 dma", r, pat & 32'h7);
            wr(12'h038, pat); rd(12'h038, r); chk("R3 mask", r, pat & 32'h7FF);
        end
        chk("R3 port lpdiv", 32'(lp_div_o), 32'h5A);
        wr(12'h038, 0);

        // R5 R6 gating sweep over enable/loopback/txen
        for (int c = 0; c < 8; c++) begin
            logic en, lb, te;
            {te, lb, en} = 3'(c);
            wr(12'h030, (32'(te) << 8) | (32'(lb) << 7) | 32'(en));
            rd(12'h030, r); chk("R3 ctrl", r, (32'(te) << 8) | (32'(lb) << 7) | 32'(en));
            wr(12'h044, 32'h30);
            wr(12'h000, 32'h40 + 32'(c));
            chk("R5 push", seen_push, en & te & ~lb);
            if (en & te & ~lb) chk("R5 data", seen_txd, 8'h40 + 8'(c));
            rd(12'h03C, r); chk("R6 tx raw", r, 32'(en & te) << 5);
        end

        // R7 receive raw + R12 pop
        wr(12'h030, 32'h301);
        rd(12'h000, r); chk("R12 empty read", r, 0); chk("R12 no pop", seen_pop, 0);
        @(negedge clk); rx_push_i = 1; rx_empty_i = 0; rx_data_i = 8'hC3;
        @(negedge clk); rx_push_i = 0;
        rd(12'h03C, r); chk("R7 rx raw set", r, 32'h30);
        rd(12'h000, r); chk("R12 data", r, 32'hC3); chk("R12 pop", seen_pop, 1);
        rx_empty_i = 1;
        @(negedge clk);
        rd(12'h03C, r); chk("R7 rx raw cleared", r, 32'h20);

        // R8 clear sweep, R9 mask sweep
        for (int m = 0; m < 4; m++) begin
            for (int cl = 0; cl < 4; cl++) begin
                logic [31:0] raw_exp;
                wr(12'h038, 0);
                @(negedge clk); rx_push_i = 1; rx_empty_i = 0;
                @(negedge clk); rx_push_i = 0;
                wr(12'h000, 32'h55);
                raw_exp = 32'h30 & ~(32'(cl) << 4);
                wr(12'h044, (32'(cl) << 4) | 32'hFFFF_FFCF);
                rd(12'h03C, r); chk("R8 raw after clear", r, raw_exp);
                wr(12'h038, 32'(m) << 4);
                rd(12'h040, r); chk("R9 masked", r, raw_exp & (32'(m) << 4));
                chk("R9 irq", irq_o, |(raw_exp & (32'(m) << 4)));
                rd(12'h044, r); chk("R10 clear reads 0", r, 0);
                rd(12'h004, r); chk("R10 rstat reads 0", r, 0);
            end
        end
        rx_empty_i = 1;
        wr(12'h044, 32'h30); wr(12'h038, 0);

        // R11 identification bytes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            case (k)
                0: e = 8'h11; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
            endcase
            rd(12'hFE0 + 12'(k * 4), r); chk("R11 id", r, 32'(e));
        end

        // R13 unmapped reads and writes; R10 status write
        wr(12'h004, 32'hFFFF_FFFF);
        for (int a = 12'h04C; a < 12'h200; a += 4) begin
            wr(12'(a), 32'hFFFF_FFFF);
            rd(12'(a), r); chk("R13 unmapped", r, 0);
        end
        for (int a = 12'h008; a < 12'h018; a += 4) begin
            rd(12'(a), r); chk("R13 gap", r, 0);
        end
        rd(12'h030, r); chk("R13 ctrl kept", r, 32'h301);
        rd(12'h03C, r); chk("R13 raw kept", r, 0);
        rd(12'h020, r); chk("R13 lpdiv kept", r, 32'h5A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule